// File: doc/BRIEF.md
# Descriptor Chain Walker

This block runs a scatter-gather transfer engine from a linked list of buffer descriptors kept in memory. Software loads a head pointer and a stop pointer. The block then reads each descriptor through a word-addressed memory port. It hands the buffer address, byte count, packet framing flags and channel identifiers to a data mover as one command. When the mover reports the bytes it moved, the block writes a completion status word back into the descriptor. It then follows the descriptor's link to the next one, and it stops after finishing the descriptor at the stop pointer. No transfer address or length is ever given through registers.

A descriptor occupies eight consecutive 32-bit words starting at its pointer. The block uses these words:
- Offset 0 holds the link to the next descriptor.
- Offset 1 holds the buffer address.
- Offset 4 holds the control word: byte count in bits 25:0, end-of-packet in bit 26, start-of-packet in bit 27.
- Offset 5 holds status: bit 31 means done, bits 25:0 hold the bytes moved.
- Offset 6 holds the channel tags: destination tag in bits 7:0, source tag in bits 15:8.

Offsets 2, 3 and 7 are never read.

The memory request and the command are valid/ready channels. Once valid is raised, it stays high with all payload fields unchanged until the cycle in which ready is seen high, so the receiver can stall the block for any number of cycles. Read data returns on a response strobe. That strobe has no ready, and the memory must return exactly one response for each accepted read, in order. The done strobe from the mover is likewise a one-cycle pulse with no back-pressure.

Top module: `sg_chain_walker`

## Requirements
- R1: Out of reset the block is not busy, shows no error and no interrupt, and drives no memory request and no command.
- R2: A stop-pointer write while the run input is high and the block is idle starts a walk at the head pointer. For each descriptor the block reads offsets 0, 1, 4, 5 and 6 from the descriptor pointer, in that order, one read outstanding at a time.
- R3: The command carries: the buffer address from offset 1; the byte count from bits 25:0 of offset 4; start-of-packet from bit 27 and end-of-packet from bit 26 of offset 4; the source tag from bits 15:8 and the destination tag from bits 7:0 of offset 6.
- R4: Memory requests and commands keep valid high, with stable payload, until accepted.
- R5: After the done strobe, the block writes status {bit31=1, bits30:26=0, bits25:0=reported bytes} to offset 5 of the current descriptor.
- R6: After each writeback the block moves to the link from offset 0. It stops after the descriptor whose pointer equals the stop pointer, and the head pointer then holds that descriptor's link.
- R7: A stop-pointer write while busy only moves the stop point. The walk continues through the extended chain without restarting.
- R8: A stop-pointer write while run is low starts nothing. A head-pointer write while busy is ignored.
- R9: If a fetched status word already has bit 31 set, the block issues no command and no writeback for that descriptor. It halts with the error output high, and the error output clears when run goes low.
- R10: A one-cycle interrupt pulse follows the writeback of the stop descriptor when the interrupt enable is high. No pulse is raised when the enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Run/stop control level |
| ioc_en | input | 1 | Interrupt-on-complete enable |
| head_we | input | 1 | Head-pointer write strobe |
| head_wdata | input | ADDR_W | Head-pointer write value (word address) |
| stop_we | input | 1 | Stop-pointer write strobe |
| stop_wdata | input | ADDR_W | Stop-pointer write value (word address) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Word address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read data |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Transfer command accepted |
| cmd_addr | output | 32 | Buffer address |
| cmd_len | output | 26 | Byte count |
| cmd_sof | output | 1 | Start-of-packet flag |
| cmd_eof | output | 1 | End-of-packet flag |
| cmd_tid | output | 8 | Source channel tag |
| cmd_tdest | output | 8 | Destination channel tag |
| done_valid | input | 1 | Transfer finished strobe |
| done_bytes | input | 26 | Bytes actually moved |
| busy | output | 1 | Walk in progress |
| err | output | 1 | Halted on a descriptor already marked done |
| irq | output | 1 | Interrupt-on-complete pulse |

## Verification
The hardest case to reach from the ports is a stop-pointer write that lands while a descriptor is still being fetched or moved. The bench stalls the memory and the mover with a pseudo-random ready pattern and a fixed mover latency, so every fetch lasts several cycles. It writes the new stop pointer a few cycles after the walk starts. In the same window it writes a stray head pointer, and the scoreboard must still see both descriptors in link order with a single interrupt. A second hard case is a descriptor whose status is already marked done. The bench places one in memory and expects exactly four reads, no command and a raised error.

// File: rtl/sg_walk_pkg.sv
package sg_walk_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_WAIT,
    S_CMD,
    S_XFER,
    S_WB,
    S_ERR
  } walk_state_e;

  localparam int LEN_W = 26;
  localparam int TAG_W = 8;

  localparam logic [2:0] W_LINK = 3'd0;
  localparam logic [2:0] W_BUF  = 3'd1;
  localparam logic [2:0] W_CTRL = 3'd4;
  localparam logic [2:0] W_STAT = 3'd5;
  localparam logic [2:0] W_TAGS = 3'd6;

  localparam int B_DONE = 31;
  localparam int B_SOF  = 27;
  localparam int B_EOF  = 26;

  // descriptor words fetched in order: 0, 1, 4, 5, 6
  function automatic logic [2:0] next_word(input logic [2:0] w);
    return (w == W_BUF) ? W_CTRL : w + 3'd1;
  endfunction

endpackage

// File: rtl/sg_ptr_regs.sv
module sg_ptr_regs #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              idle,
  input  logic              head_we,
  input  logic [ADDR_W-1:0] head_wdata,
  input  logic              stop_we,
  input  logic [ADDR_W-1:0] stop_wdata,
  input  logic              advance,
  input  logic [ADDR_W-1:0] link_ptr,
  output logic [ADDR_W-1:0] head_q,
  output logic [ADDR_W-1:0] stop_q,
  output logic              start
);

  assign start = stop_we && run && idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      stop_q <= '0;
    end else begin
      if (advance)              head_q <= link_ptr;
      else if (head_we && idle) head_q <= head_wdata;
      if (stop_we)              stop_q <= stop_wdata;
    end
  end

  // R8: head pointer frozen while the walk is running, except when following a link
  p_head_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !advance) |=> $stable(head_q));

endmodule

// File: rtl/sg_walker_fsm.sv
module sg_walker_fsm
  import sg_walk_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ioc_en,
  input  logic              start,
  input  logic [ADDR_W-1:0] head_q,
  input  logic [ADDR_W-1:0] stop_q,
  output logic              idle,
  output logic              advance,
  output logic [ADDR_W-1:0] link_ptr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [31:0]       cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_sof,
  output logic              cmd_eof,
  output logic [TAG_W-1:0]  cmd_tid,
  output logic [TAG_W-1:0]  cmd_tdest,
  input  logic              done_valid,
  input  logic [LEN_W-1:0]  done_bytes,
  output logic              busy,
  output logic              err,
  output logic              irq
);

  walk_state_e         state;
  logic [2:0]          widx;
  logic [ADDR_W-1:0]   link_q;
  logic [31:0]         buf_q;
  logic [27:0]         ctrl_q;
  logic [2*TAG_W-1:0]  tags_q;
  logic [LEN_W-1:0]    bytes_q;
  logic                at_stop;

  assign at_stop = (head_q == stop_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      widx    <= W_LINK;
      link_q  <= '0;
      buf_q   <= '0;
      ctrl_q  <= '0;
      tags_q  <= '0;
      bytes_q <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          widx  <= W_LINK;
          state <= S_RD_REQ;
        end
        S_RD_REQ: if (mem_req_ready) state <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rsp_valid) begin
          if (widx == W_LINK) link_q <= mem_rsp_data[ADDR_W-1:0];
          if (widx == W_BUF)  buf_q  <= mem_rsp_data;
          if (widx == W_CTRL) ctrl_q <= mem_rsp_data[27:0];
          if (widx == W_TAGS) tags_q <= mem_rsp_data[2*TAG_W-1:0];
          if (widx == W_STAT && mem_rsp_data[B_DONE]) state <= S_ERR;
          else if (widx == W_TAGS)                    state <= S_CMD;
          else begin
            widx  <= next_word(widx);
            state <= S_RD_REQ;
          end
        end
        S_CMD: if (cmd_ready) state <= S_XFER;
        S_XFER: if (done_valid) begin
          bytes_q <= done_bytes;
          state   <= S_WB;
        end
        S_WB: if (mem_req_ready) begin
          if (at_stop) begin
            state <= S_IDLE;
            irq   <= ioc_en;
          end else begin
            widx  <= W_LINK;
            state <= S_RD_REQ;
          end
        end
        S_ERR: if (!run) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign idle          = (state == S_IDLE);
  assign busy          = !idle && (state != S_ERR);
  assign err           = (state == S_ERR);
  assign advance       = (state == S_WB) && mem_req_ready;
  assign link_ptr      = link_q;
  assign mem_req_valid = (state == S_RD_REQ) || (state == S_WB);
  assign mem_req_write = (state == S_WB);
  assign mem_req_addr  = head_q + ADDR_W'((state == S_WB) ? W_STAT : widx);
  assign mem_req_wdata = {1'b1, 5'b0, bytes_q};
  assign cmd_valid     = (state == S_CMD);
  assign cmd_addr      = buf_q;
  assign cmd_len       = ctrl_q[LEN_W-1:0];
  assign cmd_sof       = ctrl_q[B_SOF];
  assign cmd_eof       = ctrl_q[B_EOF];
  assign cmd_tid       = tags_q[2*TAG_W-1:TAG_W];
  assign cmd_tdest     = tags_q[TAG_W-1:0];

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_tid) && $stable(cmd_tdest)));

  p_rsp_expected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (state == S_RD_WAIT));

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!cmd_valid && !mem_req_valid && !busy));

  p_irq_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (idle && !busy));

  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
  import sg_walk_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ioc_en,
  input  logic              head_we,
  input  logic [ADDR_W-1:0] head_wdata,
  input  logic              stop_we,
  input  logic [ADDR_W-1:0] stop_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [31:0]       cmd_addr,
  output logic [25:0]       cmd_len,
  output logic              cmd_sof,
  output logic              cmd_eof,
  output logic [7:0]        cmd_tid,
  output logic [7:0]        cmd_tdest,
  input  logic              done_valid,
  input  logic [25:0]       done_bytes,
  output logic              busy,
  output logic              err,
  output logic              irq
);

  logic              idle_w;
  logic              advance_w;
  logic              start_w;
  logic [ADDR_W-1:0] link_w;
  logic [ADDR_W-1:0] head_w;
  logic [ADDR_W-1:0] stop_w;

  sg_ptr_regs #(.ADDR_W(ADDR_W)) ptr_i (
    .clk(clk), .rst_n(rst_n), .run(run), .idle(idle_w),
    .head_we(head_we), .head_wdata(head_wdata),
    .stop_we(stop_we), .stop_wdata(stop_wdata),
    .advance(advance_w), .link_ptr(link_w),
    .head_q(head_w), .stop_q(stop_w), .start(start_w)
  );

  sg_walker_fsm #(.ADDR_W(ADDR_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .run(run), .ioc_en(ioc_en),
    .start(start_w), .head_q(head_w), .stop_q(stop_w),
    .idle(idle_w), .advance(advance_w), .link_ptr(link_w),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_sof(cmd_sof), .cmd_eof(cmd_eof),
    .cmd_tid(cmd_tid), .cmd_tdest(cmd_tdest), .done_valid(done_valid),
    .done_bytes(done_bytes), .busy(busy), .err(err), .irq(irq)
  );

endmodule

// File: tb/sg_chain_walker_tb.sv
module sg_chain_walker_tb_top;

  typedef struct packed {
    logic [31:0] addr;
    logic [25:0] len;
    logic        sof;
    logic        eof;
    logic [7:0]  tid;
    logic [7:0]  tdest;
  } cmd_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, ioc_en = 1'b0;
  logic head_we = 1'b0, stop_we = 1'b0;
  logic [15:0] head_wdata = '0, stop_wdata = '0;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic cmd_valid, cmd_sof, cmd_eof;
  logic cmd_ready = 1'b0;
  logic [31:0] cmd_addr;
  logic [25:0] cmd_len;
  logic [7:0] cmd_tid, cmd_tdest;
  logic done_valid = 1'b0;
  logic [25:0] done_bytes = '0;
  logic busy, err, irq;

  always #4 clk = ~clk;

  sg_chain_walker dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .ioc_en(ioc_en),
    .head_we(head_we), .head_wdata(head_wdata), .stop_we(stop_we), .stop_wdata(stop_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_sof(cmd_sof), .cmd_eof(cmd_eof), .cmd_tid(cmd_tid), .cmd_tdest(cmd_tdest),
    .done_valid(done_valid), .done_bytes(done_bytes), .busy(busy), .err(err), .irq(irq)
  );

  int checks = 0, errors = 0, cycles = 0, irq_cnt = 0, cmd_cnt = 0;
  logic [31:0] mem [0:255];
  cmd_t        exp_cmd[$];
  logic [15:0] exp_rd[$];
  logic [47:0] exp_wb[$];
  logic [7:0]  lfsr = 8'h5A;
  logic        pend = 1'b0;
  int          dly = 0;
  logic [25:0] plen = '0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory and data-mover models
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready <= lfsr[0] | lfsr[3];
    cmd_ready     <= lfsr[1] | lfsr[6];
    mem_rsp_valid <= 1'b0;
    done_valid    <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) mem[mem_req_addr[7:0]] = mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[7:0]];
      end
    end
    if (cmd_valid && cmd_ready) begin
      pend <= 1'b1; dly <= 3; plen <= cmd_len;
    end else if (pend) begin
      if (dly == 0) begin
        done_valid <= 1'b1; done_bytes <= plen; pend <= 1'b0;
      end else dly <= dly - 1;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_cnt++;
      if (prev_stall) chk(cmd_valid && cmd_addr == prev_addr, "R4 cmd hold", {31'b0, cmd_valid, cmd_addr}, {32'd1, prev_addr});
      prev_stall = cmd_valid && !cmd_ready;
      prev_addr  = cmd_addr;
      if (cmd_valid && cmd_ready) begin
        cmd_t got, e;
        cmd_cnt++;
        got = '{cmd_addr, cmd_len, cmd_sof, cmd_eof, cmd_tid, cmd_tdest};
        if (exp_cmd.size() == 0) chk(1'b0, "R3 unexpected command", 64'(got), 64'd0);
        else begin
          e = exp_cmd.pop_front();
          chk(got == e, "R3 command fields", 64'(got), 64'(e));
        end
      end
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          if (exp_wb.size() == 0) chk(1'b0, "R5 unexpected writeback", {mem_req_addr, mem_req_wdata}, 64'd0);
          else begin
            logic [47:0] w;
            w = exp_wb.pop_front();
            chk({mem_req_addr, mem_req_wdata} == w, "R5 writeback", {mem_req_addr, mem_req_wdata}, 64'(w));
          end
        end else begin
          if (exp_rd.size() == 0) chk(1'b0, "R2 unexpected read", 64'(mem_req_addr), 64'd0);
          else begin
            logic [15:0] a;
            a = exp_rd.pop_front();
            chk(mem_req_addr == a, "R2 read order", 64'(mem_req_addr), 64'(a));
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(1'b0, "watchdog", 64'(cycles), 64'd100000);
      finish_run();
    end
  end

  task automatic put_desc(input logic [7:0] base, input logic [7:0] link, input logic [31:0] bufa,
                          input logic [25:0] len, input logic sof, input logic eof,
                          input logic [7:0] tid, input logic [7:0] tdest, input logic [31:0] stat);
    mem[base]     = {24'b0, link};
    mem[base + 1] = bufa;
    mem[base + 4] = {4'b0, sof, eof, len};
    mem[base + 5] = stat;
    mem[base + 6] = {16'b0, tid, tdest};
  endtask

  // driver: pushes the expected reads, command and writeback of one descriptor
  task automatic expect_desc(input logic [7:0] base, input logic [31:0] bufa, input logic [25:0] len,
                             input logic sof, input logic eof, input logic [7:0] tid, input logic [7:0] tdest);
    exp_rd.push_back(16'(base));
    exp_rd.push_back(16'(base + 1));
    exp_rd.push_back(16'(base + 4));
    exp_rd.push_back(16'(base + 5));
    exp_rd.push_back(16'(base + 6));
    exp_cmd.push_back('{bufa, len, sof, eof, tid, tdest});
    exp_wb.push_back({16'(base + 5), 6'b100000, len});
  endtask

  task automatic write_head(input logic [15:0] v);
    @(negedge clk); head_we = 1'b1; head_wdata = v;
    @(negedge clk); head_we = 1'b0;
  endtask

  task automatic write_stop(input logic [15:0] v);
    @(negedge clk); stop_we = 1'b1; stop_wdata = v;
    @(negedge clk); stop_we = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_drained(input string req);
    chk(exp_cmd.size() == 0 && exp_rd.size() == 0 && exp_wb.size() == 0, req,
        64'(exp_cmd.size() + exp_rd.size() + exp_wb.size()), 64'd0);
  endtask

  initial begin
    int i0, c0;
    for (int k = 0; k < 256; k++) mem[k] = '0;
    repeat (4) @(negedge clk);
    chk(!busy && !err && !irq, "R1 reset status", {busy, err, irq}, 3'b000);
    chk(!cmd_valid && !mem_req_valid, "R1 reset valids", {cmd_valid, mem_req_valid}, 2'b00);
    rst_n = 1'b1;

    // three-descriptor chain with interrupt enabled
    put_desc(8'h10, 8'h20, 32'h1000_0000, 26'd64,  1'b1, 1'b0, 8'h01, 8'h0A, 32'h0);
    put_desc(8'h20, 8'h30, 32'h2000_0040, 26'd100, 1'b0, 1'b0, 8'h02, 8'h0B, 32'h0);
    put_desc(8'h30, 8'h40, 32'h3000_0100, 26'h3FFFFFF, 1'b0, 1'b1, 8'hFF, 8'h80, 32'h0);
    expect_desc(8'h10, 32'h1000_0000, 26'd64,  1'b1, 1'b0, 8'h01, 8'h0A);
    expect_desc(8'h20, 32'h2000_0040, 26'd100, 1'b0, 1'b0, 8'h02, 8'h0B);
    expect_desc(8'h30, 32'h3000_0100, 26'h3FFFFFF, 1'b0, 1'b1, 8'hFF, 8'h80);
    write_head(16'h10);
    run = 1'b1; ioc_en = 1'b1;
    i0 = irq_cnt;
    write_stop(16'h30);
    wait_idle();
    chk_drained("R6 chain walked to stop");
    chk(irq_cnt - i0 == 1, "R10 one irq", 64'(irq_cnt - i0), 64'd1);
    chk(mem[8'h15] == 32'h8000_0040, "R5 status in memory", 64'(mem[8'h15]), 64'h8000_0040);

    // head pointer must now hold the link of the stop descriptor (0x40)
    put_desc(8'h40, 8'h50, 32'h4000_0000, 26'd8, 1'b1, 1'b1, 8'h03, 8'h0C, 32'h0);
    expect_desc(8'h40, 32'h4000_0000, 26'd8, 1'b1, 1'b1, 8'h03, 8'h0C);
    write_stop(16'h40);
    wait_idle();
    chk_drained("R6 resume at stop link");

    // extend while busy; a stray head write must be ignored
    put_desc(8'h50, 8'h60, 32'h5000_0000, 26'd12, 1'b1, 1'b0, 8'h04, 8'h0D, 32'h0);
    put_desc(8'h60, 8'h70, 32'h6000_0000, 26'd20, 1'b0, 1'b1, 8'h05, 8'h0E, 32'h0);
    expect_desc(8'h50, 32'h5000_0000, 26'd12, 1'b1, 1'b0, 8'h04, 8'h0D);
    expect_desc(8'h60, 32'h6000_0000, 26'd20, 1'b0, 1'b1, 8'h05, 8'h0E);
    i0 = irq_cnt;
    write_stop(16'h50);
    chk(busy, "R2 busy after start", 64'(busy), 64'd1);
    write_stop(16'h60);
    write_head(16'h10);
    wait_idle();
    chk_drained("R7 extended chain, R8 head write ignored");
    chk(irq_cnt - i0 == 1, "R7 single irq", 64'(irq_cnt - i0), 64'd1);

    // stop write with run low starts nothing
    run = 1'b0;
    put_desc(8'h70, 8'h80, 32'h7000_0000, 26'd4, 1'b0, 1'b0, 8'h06, 8'h0F, 32'h0);
    c0 = cmd_cnt;
    write_stop(16'h70);
    repeat (40) @(negedge clk);
    chk(cmd_cnt == c0 && !busy, "R8 no start without run", 64'(cmd_cnt - c0), 64'd0);
    run = 1'b1;
    expect_desc(8'h70, 32'h7000_0000, 26'd4, 1'b0, 1'b0, 8'h06, 8'h0F);
    write_stop(16'h70);
    wait_idle();
    chk_drained("R8 start after run");

    // interrupt disabled
    ioc_en = 1'b0;
    put_desc(8'h80, 8'h90, 32'h8000_0000, 26'd1, 1'b1, 1'b1, 8'h07, 8'h10, 32'h0);
    expect_desc(8'h80, 32'h8000_0000, 26'd1, 1'b1, 1'b1, 8'h07, 8'h10);
    i0 = irq_cnt;
    write_stop(16'h80);
    wait_idle();
    chk_drained("R10 disabled walk");
    chk(irq_cnt == i0, "R10 no irq when disabled", 64'(irq_cnt - i0), 64'd0);

    // descriptor already marked done
    put_desc(8'h90, 8'hA0, 32'h9000_0000, 26'd16, 1'b0, 1'b0, 8'h08, 8'h11, 32'h8000_0010);
    exp_rd.push_back(16'h90); exp_rd.push_back(16'h91);
    exp_rd.push_back(16'h94); exp_rd.push_back(16'h95);
    c0 = cmd_cnt;
    write_stop(16'h90);
    repeat (40) @(negedge clk);
    chk(err && !busy, "R9 halted with error", {busy, err}, 2'b01);
    chk(cmd_cnt == c0, "R9 no command", 64'(cmd_cnt - c0), 64'd0);
    chk_drained("R9 reads stop at status");
    run = 1'b0;
    repeat (2) @(negedge clk);
    chk(!err, "R9 error cleared by run low", 64'(err), 64'd0);

    finish_run();
  end

endmodule